// File: doc/BRIEF.md
# Two-Layer Bus Matrix with Per-Port Arbitration

This block joins two independent master layers, one carrying instruction fetches and one carrying data accesses, to four slave ports. Each layer offers a single transfer at a time: a request flag, an address, a write flag, an opaque control word and write data. Two address bits choose the target port. Every slave port has its own small ownership machine, so the two layers can be served by different ports in the same cycle. Only a clash on one port needs a decision, and that decision always favours the data layer.

Each port machine has four states. `PARK_D` and `PARK_I` mean the port is idle and parked on a layer. `BUSY_D` and `BUSY_I` mean a transfer for that layer is in its data phase and the slave has not yet answered. A request from the parked layer passes straight through to the slave in the same cycle. The transitions are:

- **direct**: a PARK state serves its own layer.
- **handover**: a PARK state moves to the other layer's BUSY state. This costs one dead cycle.
- **stall**: a PARK state moves to its own layer's BUSY state when the slave is not ready.
- **wait**: a BUSY state holds while the slave is not ready.
- **finish**: a BUSY state returns to its own layer's PARK state.
- **pass-on**: at the end of a transfer, the port moves straight to the other layer's BUSY state because that layer is waiting.

A layer that is not being served sees its ready flag low. It must hold its request until ready is high.

Top module: `lyr_xbar`

## Requirements
- R1: The target port is address bits [SEL_LSB+1:SEL_LSB], with default SEL_LSB = 28. A served request asserts `sp_sel` only on that port. That port's address, write flag, control word and write data come from the served layer. The other address bits have no effect on the choice of port.
- R2: After reset, every port is parked on the data layer (`sp_mst` = all ones). No `sp_sel` is asserted, and both layer ready flags are low.
- R3: A request to a port parked on the same layer reaches the slave in the same cycle. If the slave is ready, the layer's ready flag rises in that cycle.
- R4: A request to an idle port parked on the other layer costs one handover cycle. In that cycle `sp_sel` stays low and the layer is stalled. The request is presented in the next cycle.
- R5: When both layers request the same idle port, the data layer is served first. The instruction layer's ready flag stays low.
- R6: Requests from the two layers to different ports are served in the same cycle.
- R7: While the slave holds ready low, the port keeps `sp_sel` high for the same owner. The owner's ready flag stays low.
- R8: If the other layer is waiting when a transfer completes (slave ready with `sp_sel` high), the port serves that layer in the very next cycle.
- R9: A layer's ready flag is the ready of the port serving it, and its read data is that port's read data. A layer that is not served sees ready low and read data zero.
- R10: After a transfer completes with no waiting layer, the port stays parked on the layer it just served.
- R11: `sp_mst` shows the owning layer of each port: 1 means data and 0 means instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ins_req | input | 1 | Instruction layer transfer request |
| ins_addr | input | AW | Instruction layer address |
| ins_wr | input | 1 | Instruction layer write flag |
| ins_ctl | input | CW | Instruction layer control word |
| ins_wdata | input | DW | Instruction layer write data |
| ins_rdy | output | 1 | Instruction layer transfer done |
| ins_rdata | output | DW | Instruction layer read data |
| dat_req | input | 1 | Data layer transfer request |
| dat_addr | input | AW | Data layer address |
| dat_wr | input | 1 | Data layer write flag |
| dat_ctl | input | CW | Data layer control word |
| dat_wdata | input | DW | Data layer write data |
| dat_rdy | output | 1 | Data layer transfer done |
| dat_rdata | output | DW | Data layer read data |
| sp_sel | output | 4 | Per-port select |
| sp_mst | output | 4 | Per-port owner (1 = data) |
| sp_addr | output | 4 x AW | Per-port address |
| sp_wr | output | 4 | Per-port write flag |
| sp_ctl | output | 4 x CW | Per-port control word |
| sp_wdata | output | 4 x DW | Per-port write data |
| sp_rdy | input | 4 | Per-port slave ready |
| sp_rdata | input | 4 x DW | Per-port read data |

## Verification
Two events can fall in the same cycle on one port: the completion of a transfer for one layer and the arrival of a request from the other layer. The bench provokes this by holding both requests on one port while the slave withholds ready, and then releasing ready. It then checks that the finishing layer alone sees ready in that cycle, and that the waiting layer is selected one cycle later with its own address. The bench also lets two ports serve the two layers in the same cycle, and checks that each layer receives only its own port's read data.

// File: rtl/lyr_xbar_pkg.sv
package lyr_xbar_pkg;
    localparam int PSEL_W = 2;
    localparam int NP     = 1 << PSEL_W;

    typedef enum logic [1:0] {
        PARK_D = 2'd0,
        PARK_I = 2'd1,
        BUSY_D = 2'd2,
        BUSY_I = 2'd3
    } arb_state_e;
endpackage

// File: rtl/lyr_addr_dec.sv
module lyr_addr_dec
    import lyr_xbar_pkg::*;
(
    input  logic              req,
    input  logic [PSEL_W-1:0] field,
    output logic [NP-1:0]     hit
);
    for (genvar p = 0; p < NP; p++) begin : g_hit
        assign hit[p] = req && (field == PSEL_W'(p));
    end
endmodule

// File: rtl/lyr_port_arb.sv
module lyr_port_arb
    import lyr_xbar_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic req_d,
    input  logic s_rdy,
    output logic sel,
    output logic mst,
    output logic srv_i,
    output logic srv_d
);
    arb_state_e st, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= PARK_D;
        else        st <= nxt;
    end

    // next state
    always_comb begin
        nxt = st;
        unique case (st)
            PARK_D: begin
                if (req_d) begin
                    if (!s_rdy)     nxt = BUSY_D;   // stall
                    else if (req_i) nxt = BUSY_I;   // pass-on
                end else if (req_i) begin
                    nxt = BUSY_I;                   // handover
                end
            end
            PARK_I: begin
                if (req_d)               nxt = BUSY_D; // handover, data wins
                else if (req_i && !s_rdy) nxt = BUSY_I; // stall
            end
            BUSY_D: if (s_rdy) nxt = req_i ? BUSY_I : PARK_D; // pass-on / finish
            BUSY_I: if (s_rdy) nxt = req_d ? BUSY_D : PARK_I; // pass-on / finish
            default: nxt = PARK_D;
        endcase
    end

    // outputs
    always_comb begin
        sel = 1'b0;
        mst = 1'b1;
        unique case (st)
            PARK_D: begin sel = req_d;           mst = 1'b1; end
            PARK_I: begin sel = req_i && !req_d; mst = 1'b0; end
            BUSY_D: begin sel = 1'b1;            mst = 1'b1; end
            BUSY_I: begin sel = 1'b1;            mst = 1'b0; end
            default: begin sel = 1'b0;           mst = 1'b1; end
        endcase
    end

    assign srv_i = sel && !mst;
    assign srv_d = sel &&  mst;
endmodule

// File: rtl/lyr_rsp_route.sv
module lyr_rsp_route
    import lyr_xbar_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [NP-1:0]         srv,
    input  logic [NP-1:0]         sp_rdy,
    input  logic [NP-1:0][DW-1:0] sp_rdata,
    output logic                  rdy,
    output logic [DW-1:0]         rdata
);
    always_comb begin
        rdy   = 1'b0;
        rdata = '0;
        for (int p = 0; p < NP; p++) begin
            if (srv[p] && sp_rdy[p]) begin
                rdy   = 1'b1;
                rdata = rdata | sp_rdata[p];
            end
        end
    end
endmodule

// File: rtl/lyr_xbar.sv
module lyr_xbar
    import lyr_xbar_pkg::*;
#(
    parameter int AW      = 32,
    parameter int DW      = 32,
    parameter int CW      = 4,
    parameter int SEL_LSB = 28
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ins_req,
    input  logic [AW-1:0]         ins_addr,
    input  logic                  ins_wr,
    input  logic [CW-1:0]         ins_ctl,
    input  logic [DW-1:0]         ins_wdata,
    output logic                  ins_rdy,
    output logic [DW-1:0]         ins_rdata,
    input  logic                  dat_req,
    input  logic [AW-1:0]         dat_addr,
    input  logic                  dat_wr,
    input  logic [CW-1:0]         dat_ctl,
    input  logic [DW-1:0]         dat_wdata,
    output logic                  dat_rdy,
    output logic [DW-1:0]         dat_rdata,
    output logic [NP-1:0]         sp_sel,
    output logic [NP-1:0]         sp_mst,
    output logic [NP-1:0][AW-1:0] sp_addr,
    output logic [NP-1:0]         sp_wr,
    output logic [NP-1:0][CW-1:0] sp_ctl,
    output logic [NP-1:0][DW-1:0] sp_wdata,
    input  logic [NP-1:0]         sp_rdy,
    input  logic [NP-1:0][DW-1:0] sp_rdata
);
    logic [NP-1:0] hit_i, hit_d, srv_i, srv_d;

    lyr_addr_dec u_dec_i (
        .req   (ins_req),
        .field (ins_addr[SEL_LSB +: PSEL_W]),
        .hit   (hit_i)
    );

    lyr_addr_dec u_dec_d (
        .req   (dat_req),
        .field (dat_addr[SEL_LSB +: PSEL_W]),
        .hit   (hit_d)
    );

    for (genvar p = 0; p < NP; p++) begin : g_port
        lyr_port_arb u_arb (
            .clk   (clk),
            .rst_n (rst_n),
            .req_i (hit_i[p]),
            .req_d (hit_d[p]),
            .s_rdy (sp_rdy[p]),
            .sel   (sp_sel[p]),
            .mst   (sp_mst[p]),
            .srv_i (srv_i[p]),
            .srv_d (srv_d[p])
        );

        assign sp_addr[p]  = sp_mst[p] ? dat_addr  : ins_addr;
        assign sp_wr[p]    = sp_mst[p] ? dat_wr    : ins_wr;
        assign sp_ctl[p]   = sp_mst[p] ? dat_ctl   : ins_ctl;
        assign sp_wdata[p] = sp_mst[p] ? dat_wdata : ins_wdata;
    end

    lyr_rsp_route #(.DW(DW)) u_rsp_i (
        .srv      (srv_i),
        .sp_rdy   (sp_rdy),
        .sp_rdata (sp_rdata),
        .rdy      (ins_rdy),
        .rdata    (ins_rdata)
    );

    lyr_rsp_route #(.DW(DW)) u_rsp_d (
        .srv      (srv_d),
        .sp_rdy   (sp_rdy),
        .sp_rdata (sp_rdata),
        .rdy      (dat_rdy),
        .rdata    (dat_rdata)
    );
endmodule

// File: rtl/lyr_xbar_chk.sv
module lyr_xbar_chk
    import lyr_xbar_pkg::*;
#(
    parameter int AW      = 32,
    parameter int SEL_LSB = 28
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  ins_req,
    input logic [AW-1:0]         ins_addr,
    input logic                  dat_req,
    input logic [AW-1:0]         dat_addr,
    input logic                  ins_rdy,
    input logic                  dat_rdy,
    input logic [NP-1:0]         sp_sel,
    input logic [NP-1:0]         sp_mst,
    input logic [NP-1:0][AW-1:0] sp_addr,
    input logic [NP-1:0]         sp_rdy
);
    logic [NP-1:0] want_i, want_d;

    always_comb begin
        for (int p = 0; p < NP; p++) begin
            want_i[p] = ins_req && (ins_addr[SEL_LSB +: PSEL_W] == PSEL_W'(p));
            want_d[p] = dat_req && (dat_addr[SEL_LSB +: PSEL_W] == PSEL_W'(p));
        end
    end

    assert_one_port_per_layer_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sp_sel & sp_mst) && $onehot0(sp_sel & ~sp_mst));

    assert_ready_routing_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_rdy == |(sp_sel & sp_mst & sp_rdy)) && (ins_rdy == |(sp_sel & ~sp_mst & sp_rdy)));

    for (genvar p = 0; p < NP; p++) begin : g_chk
        assert_data_decoded_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (sp_sel[p] && sp_mst[p]) |-> (want_d[p] && sp_addr[p] == dat_addr));

        assert_ins_decoded_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (sp_sel[p] && !sp_mst[p]) |-> (want_i[p] && sp_addr[p] == ins_addr));

        assert_data_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (!sp_sel[p] && want_i[p] && want_d[p]) |=> (sp_sel[p] && sp_mst[p]));

        assert_stall_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (sp_sel[p] && !sp_rdy[p]) |=> (sp_sel[p] && $stable(sp_mst[p])));

        assert_pass_to_ins_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (sp_sel[p] && sp_rdy[p] && sp_mst[p] && want_i[p]) |=> (sp_sel[p] && !sp_mst[p]));

        assert_pass_to_dat_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (sp_sel[p] && sp_rdy[p] && !sp_mst[p] && want_d[p]) |=> (sp_sel[p] && sp_mst[p]));

        assert_park_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (sp_sel[p] && sp_rdy[p] && !(sp_mst[p] ? want_i[p] : want_d[p]))
                |=> (sp_mst[p] == $past(sp_mst[p])));
    end
endmodule

bind lyr_xbar lyr_xbar_chk #(.AW(AW), .SEL_LSB(SEL_LSB)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ins_req  (ins_req),
    .ins_addr (ins_addr),
    .dat_req  (dat_req),
    .dat_addr (dat_addr),
    .ins_rdy  (ins_rdy),
    .dat_rdy  (dat_rdy),
    .sp_sel   (sp_sel),
    .sp_mst   (sp_mst),
    .sp_addr  (sp_addr),
    .sp_rdy   (sp_rdy)
);

// File: tb/test_lyr_xbar.sv
module test_lyr_xbar;
    localparam int AW = 32, DW = 32, CW = 4, NP = 4;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  ins_req = 1'b0, dat_req = 1'b0;
    logic [AW-1:0]         ins_addr = '0, dat_addr = '0;
    logic                  ins_wr = 1'b0, dat_wr = 1'b0;
    logic [CW-1:0]         ins_ctl = '0, dat_ctl = '0;
    logic [DW-1:0]         ins_wdata = '0, dat_wdata = '0;
    logic                  ins_rdy, dat_rdy;
    logic [DW-1:0]         ins_rdata, dat_rdata;
    logic [NP-1:0]         sp_sel, sp_mst, sp_wr;
    logic [NP-1:0][AW-1:0] sp_addr;
    logic [NP-1:0][CW-1:0] sp_ctl;
    logic [NP-1:0][DW-1:0] sp_wdata;
    logic [NP-1:0]         sp_rdy = '1;
    logic [NP-1:0][DW-1:0] sp_rdata;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    always_comb begin
        for (int p = 0; p < NP; p++) sp_rdata[p] = 32'hC0DE_0000 + 32'(p);
    end

    lyr_xbar i_lyr_xbar (.*);

    function automatic logic [AW-1:0] mk_addr(int p, logic [1:0] hi, logic [27:0] lo);
        return {hi, 2'(p), lo};
    endfunction

    task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic t_reset();
        #1;
        chk("R2", "sel after reset", 64'(sp_sel), 64'h0);
        chk("R2", "park owner after reset", 64'(sp_mst), 64'hF);
        chk("R2", "ins ready after reset", 64'(ins_rdy), 64'h0);
        chk("R2", "dat ready after reset", 64'(dat_rdy), 64'h0);
        chk("R9", "ins rdata idle", 64'(ins_rdata), 64'h0);
    endtask

    task automatic t_direct_data();
        step();
        dat_req = 1; dat_addr = mk_addr(2, 2'b10, 28'h1234560);
        dat_wr = 1; dat_ctl = 4'h5; dat_wdata = 32'h1111_2222;
        #1;
        chk("R3", "same-cycle select", 64'(sp_sel), 64'h4);
        chk("R11", "owner port2", 64'(sp_mst[2]), 64'h1);
        chk("R1", "addr port2", 64'(sp_addr[2]), 64'(dat_addr));
        chk("R1", "wr port2", 64'(sp_wr[2]), 64'h1);
        chk("R1", "ctl port2", 64'(sp_ctl[2]), 64'h5);
        chk("R1", "wdata port2", 64'(sp_wdata[2]), 64'h1111_2222);
        chk("R3", "dat ready", 64'(dat_rdy), 64'h1);
        chk("R9", "dat rdata", 64'(dat_rdata), 64'hC0DE_0002);
        chk("R9", "ins ready low", 64'(ins_rdy), 64'h0);
        step(); dat_req = 0; dat_wr = 0;
    endtask

    task automatic t_handover();
        ins_req = 1; ins_addr = mk_addr(1, 2'b00, 28'h0000040);
        #1;
        chk("R4", "handover cycle sel", 64'(sp_sel), 64'h0);
        chk("R4", "handover cycle ins ready", 64'(ins_rdy), 64'h0);
        step(); #1;
        chk("R4", "after handover sel", 64'(sp_sel), 64'h2);
        chk("R11", "owner port1 ins", 64'(sp_mst[1]), 64'h0);
        chk("R4", "ins ready", 64'(ins_rdy), 64'h1);
        chk("R9", "ins rdata", 64'(ins_rdata), 64'hC0DE_0001);
        step(); ins_req = 0; #1;
        chk("R10", "port1 parked on ins", 64'(sp_mst[1]), 64'h0);
        chk("R10", "no select idle", 64'(sp_sel), 64'h0);
        step(); ins_req = 1; ins_addr = mk_addr(1, 2'b01, 28'h0000080); #1;
        chk("R3", "ins direct on parked port", 64'(sp_sel), 64'h2);
        chk("R3", "ins direct ready", 64'(ins_rdy), 64'h1);
        step(); ins_req = 0;
    endtask

    task automatic t_contend_parked_ins();
        logic [AW-1:0] a_i, a_d;
        a_i = mk_addr(1, 2'b00, 28'h0000100);
        a_d = mk_addr(1, 2'b11, 28'h0000200);
        sp_rdy[1] = 0;
        ins_req = 1; ins_addr = a_i; dat_req = 1; dat_addr = a_d;
        #1;
        chk("R5", "handover on clash sel", 64'(sp_sel), 64'h0);
        chk("R5", "ins stalled", 64'(ins_rdy), 64'h0);
        step(); #1;
        chk("R5", "data served first", 64'(sp_sel[1] & sp_mst[1]), 64'h1);
        chk("R5", "data address", 64'(sp_addr[1]), 64'(a_d));
        chk("R7", "dat waits slave", 64'(dat_rdy), 64'h0);
        step(); #1;
        chk("R7", "stall keeps owner", 64'({sp_sel[1], sp_mst[1]}), 64'h3);
        chk("R7", "ins still stalled", 64'(ins_rdy), 64'h0);
        step(); sp_rdy[1] = 1; #1;
        chk("R8", "dat finishes", 64'(dat_rdy), 64'h1);
        chk("R8", "ins not ready at finish", 64'(ins_rdy), 64'h0);
        chk("R9", "dat rdata port1", 64'(dat_rdata), 64'hC0DE_0001);
        step(); dat_req = 0; #1;
        chk("R8", "ins granted next cycle", 64'({sp_sel[1], sp_mst[1]}), 64'h2);
        chk("R8", "ins address presented", 64'(sp_addr[1]), 64'(a_i));
        chk("R8", "ins ready", 64'(ins_rdy), 64'h1);
        step(); ins_req = 0;
    endtask

    task automatic t_contend_parked_dat();
        ins_req = 1; ins_addr = mk_addr(3, 2'b00, 28'h10);
        dat_req = 1; dat_addr = mk_addr(3, 2'b00, 28'h20);
        #1;
        chk("R5", "data direct on clash", 64'({sp_sel, sp_mst[3]}), 64'h11);
        chk("R5", "dat ready", 64'(dat_rdy), 64'h1);
        chk("R5", "ins stalled", 64'(ins_rdy), 64'h0);
        step(); dat_req = 0; #1;
        chk("R8", "ins granted after data", 64'({sp_sel[3], sp_mst[3]}), 64'h2);
        chk("R8", "ins ready", 64'(ins_rdy), 64'h1);
        step(); ins_req = 0;
    endtask

    task automatic t_parallel();
        ins_req = 1; ins_addr = mk_addr(1, 2'b00, 28'h300); ins_wdata = 32'hAAAA_0001;
        dat_req = 1; dat_addr = mk_addr(2, 2'b00, 28'h400); dat_wdata = 32'hBBBB_0002;
        #1;
        chk("R6", "both ports selected", 64'(sp_sel), 64'h6);
        chk("R6", "both ready", 64'({ins_rdy, dat_rdy}), 64'h3);
        chk("R9", "ins gets port1 data", 64'(ins_rdata), 64'hC0DE_0001);
        chk("R9", "dat gets port2 data", 64'(dat_rdata), 64'hC0DE_0002);
        chk("R1", "port1 wdata", 64'(sp_wdata[1]), 64'hAAAA_0001);
        chk("R1", "port2 wdata", 64'(sp_wdata[2]), 64'hBBBB_0002);
        step(); ins_req = 0; dat_req = 0;
    endtask

    task automatic t_sweep();
        int lat[NP] = '{0, 1, 0, 1};
        for (int p = 0; p < NP; p++) begin
            dat_req = 1; dat_addr = mk_addr(p, 2'(3 - p), 28'(p * 16));
            #1;
            if (lat[p] != 0) begin
                chk("R4", "sweep handover", 64'({sp_sel, dat_rdy}), 64'h0);
                step(); #1;
            end
            chk("R1", "sweep select", 64'(sp_sel), 64'(1 << p));
            chk("R9", "sweep rdata", 64'(dat_rdata), 64'(32'hC0DE_0000 + 32'(p)));
            step(); dat_req = 0;
            step();
        end
        #1;
        chk("R9", "idle ready low", 64'({ins_rdy, dat_rdy}), 64'h0);
        chk("R9", "idle rdata zero", 64'(dat_rdata), 64'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_direct_data();
        t_handover();
        t_contend_parked_ins();
        t_contend_parked_dat();
        t_parallel();
        t_sweep();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule